// File: doc/BRIEF.md
# MAC-Triggered TCP Payload Sender

This block sits in user logic beside a transmit engine that builds TCP headers on its own. It watches the start of received Ethernet frames on one port. When the leading four bytes of a frame's destination address are all ones, it sends one short TCP payload of fixed shape through the engine on another port. The engine needs three metadata values: connection number, payload byte count and a partial payload checksum. It also needs a frame request that stays up until the engine reports that the header is done. After that report the block streams the payload, one 32-bit word per cycle.

The payload is a constant template plus one live field: the low half of the first word carries a 16-bit send sequence number. The checksum is built by a pipelined adder tree that starts on the trigger. The tree finishes well before the latest cycle at which the engine reads the checksum. A mode input selects whether the block first waits for the engine's window-available hint. That hint becomes meaningful two cycles after the metadata settle.

Top module: `mac_trig_tcp_sender`

## Requirements
- R1: A send starts only when, in an idle cycle, `rx_vld` and `rx_sof` are both high and `rx_data` equals 32'hFFFF_FFFF. Byte 0 of the frame is `rx_data[31:24]`. Any other word, or an all-ones word without `rx_sof`, starts nothing.
- R2: `pay_conn_id` (parameter CONN_ID) and `pay_len` (equal to (NW-1)*4+LAST_BYTES, 15 by default) are loaded on the clock edge that accepts a trigger. `tx_sof` never rises in the same cycle that `pay_conn_id` changes.
- R3: `pay_csum` is the 32-bit two's-complement sum over the payload of 16-bit words taken as {second byte, first byte}, with a missing odd byte read as zero. It is valid within the first three cycles of `tx_sof` and stays stable until `tx_ack`.
- R4: While `tx_sof` is high and `tx_ack` is low, `tx_sof`, `tx_eof`, `tx_len`, `pay_conn_id` and `pay_len` stay unchanged in the next cycle.
- R5: With `mode_win` high, `tx_sof` rises only on the edge after a cycle in which `win_ok` was high. `win_ok` is first looked at in the third cycle after the accepting edge, and the block keeps waiting while it is low.
- R6: With `mode_win` low, `tx_sof` is high from the second cycle after the accepting edge.
- R7: After the edge on which `tx_ack` is seen with `tx_sof` high, `tx_sof` drops and NW words follow on consecutive cycles. `tx_eof` is high only with the last word. While `tx_sof` or a word is out, `tx_len` shows LAST_BYTES mod 4, where 0 means four bytes; otherwise it is 0. `tx_ack` outside a request has no effect.
- R8: Word 0 is {BASE[31:16], seq} and word i (i>0) is BASE + i*STEP. Bytes of the last word beyond LAST_BYTES are zero. `seq` is 0 for the first send after reset and rises by one for each accepted trigger. `tx_data` is zero when no word is out.
- R9: A trigger that arrives while a send is in progress, including the cycle of the last word, is dropped. A trigger in the very next cycle is accepted.
- R10: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Received word valid |
| rx_sof | input | 1 | Received word is the first of a frame |
| rx_data | input | 32 | Received word, first byte in bits 31:24 |
| mode_win | input | 1 | 1: wait for window-available before requesting |
| win_ok | input | 1 | Window-available hint from the engine |
| tx_ack | input | 1 | Engine header done, payload may follow |
| tx_sof | output | 1 | Frame request, held until ack |
| tx_eof | output | 1 | Last payload word |
| tx_len | output | 2 | Valid bytes in the last word (0 = 4) |
| tx_data | output | 32 | Payload word |
| pay_conn_id | output | 16 | Connection number |
| pay_len | output | 16 | Payload length in bytes |
| pay_csum | output | 32 | Partial payload checksum, not complemented |

## Verification
The two functions that can meet in one cycle are the end of a send, when the final word goes out with `tx_eof`, and the acceptance of a new trigger. The bench puts an all-ones frame start on the receive side in exactly the cycle it sees `tx_eof`, and a second one in the cycle after. It expects the first to be dropped and the second to start a send with the next sequence number. The behavioural model tracks the same cycle. Its request count and the word-0 sequence field both show which trigger was taken.

// File: rtl/mts_pkg.sv
`timescale 1ns/1ps
package mts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT,
    ST_CHECK,
    ST_REQ,
    ST_STREAM
  } mts_state_e;

  // Sum of the two 16-bit halves of a network-order word, each half byte-swapped.
  function automatic logic [31:0] fold_word(input logic [31:0] w);
    return {16'h0000, w[23:16], w[31:24]} + {16'h0000, w[7:0], w[15:8]};
  endfunction

  // Keeps the first nbytes bytes (from bit 31 downward) of a word.
  function automatic logic [31:0] keep_mask(input int unsigned nbytes);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(nbytes)) m = m | (32'hFF00_0000 >> (8 * k));
    end
    return m;
  endfunction

endpackage

// File: rtl/mts_rst_sync.sv
`timescale 1ns/1ps
module mts_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/mts_trig_detect.sv
`timescale 1ns/1ps
module mts_trig_detect #(
  parameter int unsigned MATCH_BYTES = 4
) (
  input  logic        rx_vld,
  input  logic        rx_sof,
  input  logic [31:0] rx_data,
  output logic        hit
);
  logic [MATCH_BYTES-1:0] byte_ok;

  for (genvar b = 0; b < MATCH_BYTES; b++) begin : g_byte
    assign byte_ok[b] = (rx_data[31-8*b -: 8] == 8'hFF);
  end

  assign hit = rx_vld & rx_sof & (&byte_ok);
endmodule

// File: rtl/mts_payload_gen.sv
`timescale 1ns/1ps
module mts_payload_gen
  import mts_pkg::*;
#(
  parameter int unsigned NW         = 4,
  parameter int unsigned LAST_BYTES = 3,
  parameter logic [31:0] BASE       = 32'hC3A5_1E00,
  parameter logic [31:0] STEP       = 32'h0101_0203
) (
  input  logic [15:0]      seq,
  output logic [NW*32-1:0] words
);
  localparam logic [31:0] LAST_MASK = keep_mask(LAST_BYTES);

  logic [31:0] raw [NW];

  for (genvar i = 0; i < NW; i++) begin : g_word
    if (i == 0) begin : g_live
      assign raw[i] = {BASE[31:16], seq};
    end else begin : g_const
      localparam logic [31:0] CONST_W = BASE + STEP * 32'(i);
      assign raw[i] = CONST_W;
    end
    if (i == NW - 1) begin : g_tail
      assign words[i*32 +: 32] = raw[i] & LAST_MASK;
    end else begin : g_body
      assign words[i*32 +: 32] = raw[i];
    end
  end
endmodule

// File: rtl/mts_csum_tree.sv
`timescale 1ns/1ps
module mts_csum_tree
  import mts_pkg::*;
#(
  parameter int unsigned NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NW*32-1:0] words,
  output logic [31:0]      csum
);
  localparam int unsigned LVLS   = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned LEAVES = 1 << LVLS;

  logic [31:0]     leaf [LEAVES];
  logic [31:0]     node [LVLS+1][LEAVES];
  logic [LVLS-1:0] busy_q;
  logic            en;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NW) begin : g_used
      assign leaf[j] = fold_word(words[j*32 +: 32]);
    end else begin : g_pad
      assign leaf[j] = '0;
    end
  end

  assign en = start | (|busy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int l = 0; l <= LVLS; l++) begin
        for (int j = 0; j < LEAVES; j++) node[l][j] <= '0;
      end
    end else if (en) begin
      busy_q <= (busy_q << 1) | LVLS'(start);
      for (int j = 0; j < LEAVES; j++) node[0][j] <= leaf[j];
      for (int l = 1; l <= LVLS; l++) begin
        for (int j = 0; j < (LEAVES >> l); j++) begin
          node[l][j] <= node[l-1][2*j] + node[l-1][2*j+1];
        end
      end
    end
  end

  assign csum = node[LVLS][0];
endmodule

// File: rtl/mts_sequencer.sv
`timescale 1ns/1ps
module mts_sequencer
  import mts_pkg::*;
#(
  parameter int unsigned NW    = 4,
  parameter int unsigned IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             mode_win,
  input  logic             win_ok,
  input  logic             tx_ack,
  output logic             launch,
  output logic             in_req,
  output logic             in_stream,
  output logic             last_word,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);

  mts_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (hit) state_d = ST_SETTLE;
      ST_SETTLE: state_d = mode_win ? ST_WAIT : ST_REQ;
      ST_WAIT:   state_d = ST_CHECK;
      ST_CHECK:  if (win_ok) state_d = ST_REQ;
      ST_REQ: begin
        if (tx_ack) begin
          state_d = ST_STREAM;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_STREAM: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign launch    = (state_q == ST_IDLE) & hit;
  assign in_req    = (state_q == ST_REQ);
  assign in_stream = (state_q == ST_STREAM);
  assign last_word = in_stream & (idx_q == LAST_IDX);
  assign idx       = idx_q;
endmodule

// File: rtl/mac_trig_tcp_sender.sv
`timescale 1ns/1ps
module mac_trig_tcp_sender
  import mts_pkg::*;
#(
  parameter int unsigned NW         = 4,
  parameter int unsigned LAST_BYTES = 3,
  parameter logic [15:0] CONN_ID    = 16'h0042,
  parameter logic [31:0] BASE       = 32'hC3A5_1E00,
  parameter logic [31:0] STEP       = 32'h0101_0203
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_vld,
  input  logic        rx_sof,
  input  logic [31:0] rx_data,
  input  logic        mode_win,
  input  logic        win_ok,
  input  logic        tx_ack,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic [1:0]  tx_len,
  output logic [31:0] tx_data,
  output logic [15:0] pay_conn_id,
  output logic [15:0] pay_len,
  output logic [31:0] pay_csum
);
  localparam int unsigned IDX_W     = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [15:0] PAY_BYTES = 16'((NW - 1) * 4 + LAST_BYTES);
  localparam logic [1:0]  LEN_CODE  = 2'(LAST_BYTES % 4);

  logic             rst_n_i;
  logic             hit;
  logic             launch;
  logic             in_req;
  logic             in_stream;
  logic             last_word;
  logic [IDX_W-1:0] idx;
  logic [15:0]      seq_cnt_q;
  logic [15:0]      seq_hold_q;
  logic [15:0]      conn_q;
  logic [15:0]      len_q;
  logic             start_q;
  logic [NW*32-1:0] words;
  logic [31:0]      word_arr [NW];

  mts_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_i)
  );

  mts_trig_detect #(.MATCH_BYTES(4)) u_trig (
    .rx_vld  (rx_vld),
    .rx_sof  (rx_sof),
    .rx_data (rx_data),
    .hit     (hit)
  );

  mts_sequencer #(.NW(NW), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .hit       (hit),
    .mode_win  (mode_win),
    .win_ok    (win_ok),
    .tx_ack    (tx_ack),
    .launch    (launch),
    .in_req    (in_req),
    .in_stream (in_stream),
    .last_word (last_word),
    .idx       (idx)
  );

  // Metadata and sequence registers, all enabled by an accepted trigger.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      seq_cnt_q  <= '0;
      seq_hold_q <= '0;
      conn_q     <= '0;
      len_q      <= '0;
      start_q    <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        seq_cnt_q  <= seq_cnt_q + 16'd1;
        seq_hold_q <= seq_cnt_q;
        conn_q     <= CONN_ID;
        len_q      <= PAY_BYTES;
      end
    end
  end

  mts_payload_gen #(
    .NW(NW), .LAST_BYTES(LAST_BYTES), .BASE(BASE), .STEP(STEP)
  ) u_pay (
    .seq   (seq_hold_q),
    .words (words)
  );

  mts_csum_tree #(.NW(NW)) u_csum (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (start_q),
    .words (words),
    .csum  (pay_csum)
  );

  for (genvar i = 0; i < NW; i++) begin : g_arr
    assign word_arr[i] = words[i*32 +: 32];
  end

  assign tx_sof      = in_req;
  assign tx_eof      = last_word | (in_req & (NW == 1));
  assign tx_len      = (in_req | in_stream) ? LEN_CODE : 2'b00;
  assign tx_data     = in_stream ? word_arr[idx] : 32'h0;
  assign pay_conn_id = conn_q;
  assign pay_len     = len_q;
endmodule

// File: rtl/mac_trig_tcp_sender_chk.sv
`timescale 1ns/1ps
module mac_trig_tcp_sender_chk #(
  parameter int unsigned NW         = 4,
  parameter int unsigned LAST_BYTES = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_win,
  input logic        win_ok,
  input logic        tx_ack,
  input logic        tx_sof,
  input logic        tx_eof,
  input logic [1:0]  tx_len,
  input logic [15:0] pay_conn_id,
  input logic [15:0] pay_len,
  input logic [31:0] pay_csum
);
  localparam logic [1:0] LEN_CODE = 2'(LAST_BYTES % 4);

  logic [3:0] sof_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_age_q <= '0;
    else if (!tx_sof) sof_age_q <= '0;
    else if (sof_age_q != 4'hF) sof_age_q <= sof_age_q + 4'd1;
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof && !tx_ack) |=> (tx_sof && $stable(tx_eof) && $stable(tx_len)
                             && $stable(pay_conn_id) && $stable(pay_len)));

  assert_csum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof && !tx_ack && sof_age_q >= 4'd2) |=> $stable(pay_csum));

  assert_conn_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sof) |-> $stable(pay_conn_id));

  assert_win_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_sof) && mode_win && $past(mode_win)) |-> $past(win_ok));

  assert_eof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eof && !tx_sof) |=> !tx_eof);

  assert_len_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> (tx_len == LEN_CODE));
endmodule

bind mac_trig_tcp_sender mac_trig_tcp_sender_chk #(
  .NW(NW), .LAST_BYTES(LAST_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_win    (mode_win),
  .win_ok      (win_ok),
  .tx_ack      (tx_ack),
  .tx_sof      (tx_sof),
  .tx_eof      (tx_eof),
  .tx_len      (tx_len),
  .pay_conn_id (pay_conn_id),
  .pay_len     (pay_len),
  .pay_csum    (pay_csum)
);

// File: tb/mac_trig_tcp_sender_tb.sv
`timescale 1ns/1ps
module mac_trig_tcp_sender_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          NW         = 4;
  localparam int          LAST_BYTES = 3;
  localparam logic [15:0] CONN_ID    = 16'h0042;
  localparam logic [31:0] BASE       = 32'hC3A5_1E00;
  localparam logic [31:0] STEP       = 32'h0101_0203;
  localparam int          PAY_BYTES  = (NW - 1) * 4 + LAST_BYTES;
  localparam int          LVLS       = (NW > 1) ? $clog2(NW) : 1;
  localparam int          S_IDLE = 0, S_SETTLE = 1, S_WAIT = 2, S_CHECK = 3,
                          S_REQ = 4, S_STREAM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_vld = 1'b0, rx_sof = 1'b0;
  logic [31:0] rx_data = '0;
  logic        mode_win = 1'b0, win_ok = 1'b0, tx_ack = 1'b0;
  logic        tx_sof, tx_eof;
  logic [1:0]  tx_len;
  logic [31:0] tx_data, pay_csum;
  logic [15:0] pay_conn_id, pay_len;

  int n_chk = 0, n_fail = 0;
  int ack_wait = 0, ack_cnt = 0;
  int sends = 0;
  bit prev_sof = 1'b0, cmp_on = 1'b0, finished = 1'b0;

  // model state
  int          m_st = S_IDLE, m_idx = 0, m_rcnt = 0, m_cage = 0;
  logic [15:0] m_seq = '0, m_hold = '0, m_conn = '0, m_len = '0;
  logic [31:0] m_csum = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac_trig_tcp_sender #(
    .NW(NW), .LAST_BYTES(LAST_BYTES), .CONN_ID(CONN_ID), .BASE(BASE), .STEP(STEP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_data(rx_data),
    .mode_win(mode_win), .win_ok(win_ok), .tx_ack(tx_ack),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_len(tx_len), .tx_data(tx_data),
    .pay_conn_id(pay_conn_id), .pay_len(pay_len), .pay_csum(pay_csum)
  );

  function automatic logic [31:0] exp_word(int i, logic [15:0] s);
    logic [31:0] w;
    w = (i == 0) ? {BASE[31:16], s} : BASE + STEP * 32'(i);
    if (i == NW - 1)
      for (int k = LAST_BYTES; k < 4; k++) w[31-8*k -: 8] = 8'h00;
    return w;
  endfunction

  function automatic logic [7:0] exp_byte(int n, logic [15:0] s);
    logic [31:0] w;
    w = exp_word(n / 4, s);
    return w[31-8*(n%4) -: 8];
  endfunction

  function automatic logic [31:0] exp_csum(logic [15:0] s);
    logic [31:0] sum;
    logic [7:0]  lo, hi;
    sum = '0;
    for (int p = 0; p < PAY_BYTES; p += 2) begin
      lo  = exp_byte(p, s);
      hi  = (p + 1 < PAY_BYTES) ? exp_byte(p + 1, s) : 8'h00;
      sum = sum + {16'h0, hi, lo};
    end
    return sum;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit trig;
    trig = rx_vld && rx_sof && (rx_data == 32'hFFFF_FFFF);
    if (!rst_n) begin
      m_rcnt = 0; m_st = S_IDLE; m_idx = 0; m_seq = '0; m_hold = '0;
      m_conn = '0; m_len = '0; m_csum = '0; m_cage = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      if (m_cage < 1000) m_cage++;
      case (m_st)
        S_IDLE: if (trig) begin
          m_st = S_SETTLE; m_hold = m_seq; m_seq = m_seq + 16'd1;
          m_conn = CONN_ID; m_len = 16'(PAY_BYTES);
          m_csum = exp_csum(m_hold); m_cage = 0;
        end
        S_SETTLE: m_st = mode_win ? S_WAIT : S_REQ;
        S_WAIT:   m_st = S_CHECK;
        S_CHECK:  if (win_ok) m_st = S_REQ;
        S_REQ:    if (tx_ack) begin m_st = S_STREAM; m_idx = 0; end
        default:  if (m_idx == NW - 1) m_st = S_IDLE; else m_idx++;
      endcase
    end
  end

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 R5 R6 tx_sof", 32'(tx_sof), 32'(m_st == S_REQ));
      chk("R7 tx_eof", 32'(tx_eof),
          32'((m_st == S_STREAM && m_idx == NW - 1) || (m_st == S_REQ && NW == 1)));
      chk("R4 tx_len", 32'(tx_len),
          32'((m_st == S_REQ || m_st == S_STREAM) ? (LAST_BYTES % 4) : 0));
      chk("R8 tx_data", tx_data, (m_st == S_STREAM) ? exp_word(m_idx, m_hold) : 32'h0);
      chk("R2 pay_conn_id", 32'(pay_conn_id), 32'(m_conn));
      chk("R2 pay_len", 32'(pay_len), 32'(m_len));
      if (m_conn == 16'h0) chk("R3 pay_csum idle", pay_csum, 32'h0);
      else if (m_cage >= LVLS + 1) chk("R3 pay_csum", pay_csum, m_csum);
    end
  end

  // Engine stand-in: acknowledges a request after ack_wait extra cycles
  always @(negedge clk) begin
    if (tx_sof && !tx_ack) begin
      if (ack_cnt == ack_wait) tx_ack <= 1'b1;
      ack_cnt = ack_cnt + 1;
    end else begin
      tx_ack <= 1'b0;
      ack_cnt = 0;
    end
    if (tx_sof && !prev_sof) sends++;
    prev_sof = tx_sof;
  end

  task automatic frame(logic [31:0] d, logic s);
    @(negedge clk);
    rx_vld = 1'b1; rx_sof = s; rx_data = d;
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; rx_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10 tx_sof", 32'(tx_sof), 32'h0);
    chk("R10 tx_eof", 32'(tx_eof), 32'h0);
    chk("R10 tx_len", 32'(tx_len), 32'h0);
    chk("R10 tx_data", tx_data, 32'h0);
    chk("R10 pay_conn_id", 32'(pay_conn_id), 32'h0);
    chk("R10 pay_len", 32'(pay_len), 32'h0);
    chk("R10 pay_csum", pay_csum, 32'h0);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    // R1: near misses start nothing
    frame(32'hFFFF_FFFE, 1'b1); idle(10);
    frame(32'hFFFF_FFFF, 1'b0); idle(10);
    frame(32'h7FFF_FFFF, 1'b1); idle(10);
    chk("R1 no send on near-miss frames", 32'(sends), 32'd0);

    // R6 R7 R8 R3: direct mode with several ack delays
    mode_win = 1'b0;
    ack_wait = 0;  frame(32'hFFFF_FFFF, 1'b1); idle(15);
    ack_wait = 3;  frame(32'hFFFF_FFFF, 1'b1); idle(20);
    ack_wait = 12; frame(32'hFFFF_FFFF, 1'b1); idle(30);
    chk("R6 three sends in direct mode", 32'(sends), 32'd3);

    // R5: window-checked mode, hint low then high
    mode_win = 1'b1; win_ok = 1'b0; ack_wait = 1;
    frame(32'hFFFF_FFFF, 1'b1); idle(9);
    chk("R5 request held off while win_ok low", 32'(sends), 32'd3);
    win_ok = 1'b1; idle(15);
    chk("R5 request after win_ok high", 32'(sends), 32'd4);
    frame(32'hFFFF_FFFF, 1'b1); idle(15);
    chk("R5 request with win_ok already high", 32'(sends), 32'd5);
    mode_win = 1'b0; win_ok = 1'b0;

    // R7: spurious ack while idle does nothing
    @(negedge clk); tx_ack <= 1'b1;
    @(negedge clk); tx_ack <= 1'b0;
    idle(5);
    chk("R7 stray ack while idle", 32'(sends), 32'd5);

    // R9: trigger mid-send dropped, trigger on last word dropped, next accepted
    ack_wait = 2;
    frame(32'hFFFF_FFFF, 1'b1);
    idle(2);
    frame(32'hFFFF_FFFF, 1'b1);
    while (!tx_eof) @(negedge clk);
    rx_vld = 1'b1; rx_sof = 1'b1; rx_data = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; rx_data = '0;
    idle(20);
    chk("R9 busy triggers dropped, next cycle accepted", 32'(sends), 32'd7);
    chk("R8 sequence advanced once per accepted trigger", 32'(m_seq), 32'd7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule